// File: doc/BRIEF.md
# Pulse-Locked Tenths Time-of-Day Counter

This block keeps a time of day at 100 ms resolution for a display. Two inputs pace it. A one-pulse-per-second input gives the exact second boundary. A time value, delivered as BCD hours, minutes and seconds with a one-cycle load strobe, comes from a serial receiver that has already decoded it.

The received time names the second that is already under way. The block therefore adds one second to it and holds the result in a staging register. The result reaches the outputs only on the next rising pulse edge, and that edge also restarts the tenths digit at zero.

A free-running tick counter uses a prescaled clock. It is built from a low word plus a high word that advances when the low word overflows. On every pulse edge the tick count since the previous edge is captured, and one tenth of it becomes the number of ticks per tenths step until the next edge. When the lock input is low the block reports no valid time, and it neither measures nor interpolates.

Top module: `pps_tod_counter`

## Requirements
- R1: A tick occurs once every PRESCALE clock cycles. The tick count is TICK_W bits wide and is formed from a LO_W-bit low word and a high word that increments when a tick wraps the low word.
- R2: On a rising pulse edge while locked, the ticks counted since the previous rising edge are captured. The tenths step length becomes that count divided by 10, with a floor of 1 tick.
- R3: After a pulse edge, with a step length of N ticks, the tenths output equals the number of ticks counted since the edge divided by N (integer division).
- R4: The tenths output never exceeds 9. Once at 9 it holds there until the next pulse edge, even if that edge is late.
- R5: On every rising pulse edge while locked, the tenths output becomes 0 in the following cycle.
- R6: After reset, or after the lock input has been low, the tenths output stays 0 until a second rising pulse edge has been seen. The first edge only records a starting tick count.
- R7: A time loaded while locked is staged as that time plus one second, with BCD carry through seconds, minutes and hours, and 23:59:59 wraps to 00:00:00.
- R8: On a rising pulse edge while locked, a staged time moves to the hour, minute and second outputs and valid becomes 1, and the staging register is then empty. If nothing is staged, valid becomes 0 and the time outputs keep their value.
- R9: While the lock input is low, valid is 0 from the next cycle on. Pulse edges and loads are ignored, tenths is 0, and any staged time is discarded.
- R10: After reset all time outputs are 0 (BCD) and valid is 0.
- R11: A load between pulse edges does not change any output until the next pulse edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_i | input | 1 | Once-per-second pulse, synchronous level; rising edge marks the second |
| lock_i | input | 1 | Receiver has a valid fix |
| ser_load_i | input | 1 | One-cycle strobe: ser_*_i carry the current second |
| ser_hh_i | input | 8 | Received hours, BCD 00..23 |
| ser_mm_i | input | 8 | Received minutes, BCD 00..59 |
| ser_ss_i | input | 8 | Received seconds, BCD 00..59 |
| hh_o | output | 8 | Displayed hours, BCD |
| mm_o | output | 8 | Displayed minutes, BCD |
| ss_o | output | 8 | Displayed seconds, BCD |
| tenths_o | output | 4 | Displayed tenths digit, 0..9 |
| valid_o | output | 1 | Displayed time is current |

## Verification
The bench builds the block with a prescale of 2 and a 4-bit low word, keeping the 32-bit total width. At that setting the low word overflows into the high word every 16 ticks, so that carry path runs many times across each measured interval. A "second" is only a few hundred clocks long, which makes it cheap to run nominal, late and missing pulses, to change the step length between seconds, and to cover the midnight and ten-hour carries.

// File: rtl/pps_tod_pkg.sv
package pps_tod_pkg;

    localparam int unsigned STEPS_PER_SEC = 10;
    localparam logic [3:0]  TENTHS_LAST   = 4'd9;

    typedef struct packed {
        logic [7:0] hh;
        logic [7:0] mm;
        logic [7:0] ss;
    } tod_t;

    typedef enum logic [1:0] {
        SYNC_IDLE  = 2'd0,   // no edge seen since reset or lock loss
        SYNC_ARMED = 2'd1,   // one edge seen, start count recorded
        SYNC_RUN   = 2'd2    // interval measured, step length valid
    } sync_e;

    // Advance a two-digit BCD value, wrapping at the given last value.
    function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
        logic [7:0] r;
        if (v == last)
            r = 8'h00;
        else if (v[3:0] == 4'd9)
            r = {v[7:4] + 4'd1, 4'd0};
        else
            r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic tod_t tod_plus_one(input tod_t t);
        tod_t r;
        r    = t;
        r.ss = bcd_step(t.ss, 8'h59);
        if (t.ss == 8'h59) begin
            r.mm = bcd_step(t.mm, 8'h59);
            if (t.mm == 8'h59)
                r.hh = bcd_step(t.hh, 8'h23);
        end
        return r;
    endfunction

endpackage

// File: rtl/pps_tick_timebase.sv
module pps_tick_timebase #(
    parameter int unsigned PRESCALE = 8,
    parameter int unsigned TICK_W   = 32,
    parameter int unsigned LO_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              tick_o,
    output logic [TICK_W-1:0] count_o
);
    localparam int unsigned HI_W  = TICK_W - LO_W;
    localparam int unsigned PSC_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            lo_wrap;

    generate
        if (PRESCALE > 1) begin : g_div
            logic [PSC_W-1:0] psc_q;
            always_ff @(posedge clk) begin
                if (rst || tick_o) psc_q <= '0;
                else               psc_q <= psc_q + 1'b1;
            end
            assign tick_o = (psc_q == PSC_W'(PRESCALE - 1));
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate

    assign lo_wrap = &lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (tick_o) begin
            lo_q <= lo_q + 1'b1;
            if (lo_wrap) hi_q <= hi_q + 1'b1;
        end
    end

    assign count_o = {hi_q, lo_q};

    p_hi_carry_r1: assert property (@(posedge clk) disable iff (rst)
        (tick_o && lo_wrap) |=> (hi_q == $past(hi_q) + 1'b1) && (lo_q == '0));
    p_hi_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !(tick_o && lo_wrap) |=> $stable(hi_q));

endmodule

// File: rtl/pps_interval_meter.sv
module pps_interval_meter
    import pps_tod_pkg::*;
#(
    parameter int unsigned TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_i,
    input  logic              edge_i,
    input  logic [TICK_W-1:0] count_i,
    output logic [TICK_W-1:0] step_o,
    output logic              step_ok_o
);
    sync_e             state_q;
    logic [TICK_W-1:0] last_q;
    logic [TICK_W-1:0] span;
    logic [TICK_W-1:0] quo;

    assign span = count_i - last_q;
    assign quo  = span / TICK_W'(STEPS_PER_SEC);

    always_ff @(posedge clk) begin
        if (rst || !lock_i) begin
            state_q <= SYNC_IDLE;
            last_q  <= '0;
            step_o  <= TICK_W'(1);
        end else if (edge_i) begin
            last_q <= count_i;
            if (state_q == SYNC_IDLE) begin
                state_q <= SYNC_ARMED;
            end else begin
                state_q <= SYNC_RUN;
                step_o  <= (quo == '0) ? TICK_W'(1) : quo;
            end
        end
    end

    assign step_ok_o = (state_q == SYNC_RUN);

    p_step_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        step_ok_o |-> (step_o != '0));
    p_run_needs_two_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SYNC_IDLE) |=> !step_ok_o);

endmodule

// File: rtl/pps_tenths_pacer.sv
module pps_tenths_pacer
    import pps_tod_pkg::*;
#(
    parameter int unsigned TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    input  logic              tick_i,
    input  logic [TICK_W-1:0] step_i,
    input  logic              step_ok_i,
    output logic [3:0]        tenths_o
);
    logic [TICK_W-1:0] acc_q;
    logic              at_last;

    assign at_last = (tenths_o == TENTHS_LAST);

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            acc_q    <= '0;
            tenths_o <= '0;
        end else if (step_ok_i && tick_i && !at_last) begin
            if (acc_q + 1'b1 >= step_i) begin
                acc_q    <= '0;
                tenths_o <= tenths_o + 4'd1;
            end else begin
                acc_q <= acc_q + 1'b1;
            end
        end
    end

    p_tenths_range_r4: assert property (@(posedge clk) disable iff (rst)
        tenths_o <= TENTHS_LAST);
    p_hold_nine_r4: assert property (@(posedge clk) disable iff (rst)
        (at_last && !restart_i) |=> (tenths_o == TENTHS_LAST));
    p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (tenths_o == 4'd0));
    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(tenths_o) |-> (tenths_o == $past(tenths_o) + 4'd1) || (tenths_o == 4'd0));
    p_no_step_unmeasured_r6: assert property (@(posedge clk) disable iff (rst)
        (!step_ok_i && tenths_o == 4'd0) |=> (tenths_o == 4'd0));

endmodule

// File: rtl/pps_time_stager.sv
module pps_time_stager
    import pps_tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic load_i,
    input  tod_t rx_i,
    input  logic take_i,
    output tod_t staged_o,
    output logic staged_ok_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            staged_o    <= '0;
            staged_ok_o <= 1'b0;
        end else if (!lock_i) begin
            staged_ok_o <= 1'b0;
        end else if (load_i) begin
            staged_o    <= tod_plus_one(rx_i);
            staged_ok_o <= 1'b1;
        end else if (take_i) begin
            staged_ok_o <= 1'b0;
        end
    end

    p_staged_bcd_r7: assert property (@(posedge clk) disable iff (rst)
        staged_ok_o |-> (staged_o.ss <= 8'h59) && (staged_o.mm <= 8'h59) && (staged_o.hh <= 8'h23)
                        && (staged_o.ss[3:0] <= 4'd9) && (staged_o.mm[3:0] <= 4'd9)
                        && (staged_o.hh[3:0] <= 4'd9));
    p_unlock_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> !staged_ok_o);

endmodule

// File: rtl/pps_tod_counter.sv
module pps_tod_counter
    import pps_tod_pkg::*;
#(
    parameter int unsigned PRESCALE = 8,
    parameter int unsigned TICK_W   = 32,
    parameter int unsigned LO_W     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pps_i,
    input  logic       lock_i,
    input  logic       ser_load_i,
    input  logic [7:0] ser_hh_i,
    input  logic [7:0] ser_mm_i,
    input  logic [7:0] ser_ss_i,
    output logic [7:0] hh_o,
    output logic [7:0] mm_o,
    output logic [7:0] ss_o,
    output logic [3:0] tenths_o,
    output logic       valid_o
);
    logic              pps_q;
    logic              pps_rise;
    logic              tick;
    logic [TICK_W-1:0] count;
    logic [TICK_W-1:0] step;
    logic              step_ok;
    tod_t              rx_time;
    tod_t              staged;
    logic              staged_ok;
    tod_t              shown_q;

    always_ff @(posedge clk) begin
        if (rst) pps_q <= 1'b0;
        else     pps_q <= pps_i;
    end

    assign pps_rise = pps_i && !pps_q && lock_i;
    assign rx_time  = '{hh: ser_hh_i, mm: ser_mm_i, ss: ser_ss_i};

    pps_tick_timebase #(.PRESCALE(PRESCALE), .TICK_W(TICK_W), .LO_W(LO_W)) u_timebase (
        .clk     (clk),
        .rst     (rst),
        .tick_o  (tick),
        .count_o (count)
    );

    pps_interval_meter #(.TICK_W(TICK_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .lock_i    (lock_i),
        .edge_i    (pps_rise),
        .count_i   (count),
        .step_o    (step),
        .step_ok_o (step_ok)
    );

    pps_tenths_pacer #(.TICK_W(TICK_W)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (pps_rise || !lock_i),
        .tick_i    (tick),
        .step_i    (step),
        .step_ok_i (step_ok),
        .tenths_o  (tenths_o)
    );

    pps_time_stager u_stager (
        .clk         (clk),
        .rst         (rst),
        .lock_i      (lock_i),
        .load_i      (ser_load_i),
        .rx_i        (rx_time),
        .take_i      (pps_rise),
        .staged_o    (staged),
        .staged_ok_o (staged_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shown_q <= '0;
            valid_o <= 1'b0;
        end else if (!lock_i) begin
            valid_o <= 1'b0;
        end else if (pps_rise) begin
            valid_o <= staged_ok;
            if (staged_ok) shown_q <= staged;
        end
    end

    assign hh_o = shown_q.hh;
    assign mm_o = shown_q.mm;
    assign ss_o = shown_q.ss;

    p_valid_needs_lock_r9: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> !valid_o);
    p_commit_staged_r8: assert property (@(posedge clk) disable iff (rst)
        (pps_rise && staged_ok) |=> valid_o && ({hh_o, mm_o, ss_o} == $past(staged)));
    p_hold_between_r11: assert property (@(posedge clk) disable iff (rst)
        !pps_rise |=> $stable({hh_o, mm_o, ss_o}));

endmodule

// File: tb/pps_tod_counter_tb.sv
module pps_tod_counter_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PSC        = 2;
    localparam int  TIMEOUT    = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pps = 1'b0;
    logic       lock = 1'b0;
    logic       ld = 1'b0;
    logic [7:0] s_hh = 8'h00, s_mm = 8'h00, s_ss = 8'h00;
    logic [7:0] hh, mm, ss;
    logic [3:0] tenths;
    logic       valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pps_tod_counter #(.PRESCALE(PSC), .TICK_W(32), .LO_W(4)) u_dut (
        .clk(clk), .rst(rst), .pps_i(pps), .lock_i(lock), .ser_load_i(ld),
        .ser_hh_i(s_hh), .ser_mm_i(s_mm), .ser_ss_i(s_ss),
        .hh_o(hh), .mm_o(mm), .ss_o(ss), .tenths_o(tenths), .valid_o(valid)
    );

    // ---------------- behavioural reference ----------------
    int m_cyc, m_since, m_n, m_step, m_edges, m_st_sec, m_disp_sec;
    bit m_pps_q, m_ok, m_st_ok, m_valid;

    function automatic int bcd2int(input logic [7:0] b);
        return b[7:4] * 10 + b[3:0];
    endfunction
    function automatic logic [7:0] int2bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction
    function automatic logic [23:0] sec2bcd(input int t);
        return {int2bcd(t / 3600), int2bcd((t / 60) % 60), int2bcd(t % 60)};
    endfunction

    always @(posedge clk) begin
        bit tk, rise;
        if (rst) begin
            m_cyc = 0; m_since = 0; m_n = 0; m_step = 1; m_edges = 0;
            m_st_sec = 0; m_disp_sec = 0;
            m_pps_q = 0; m_ok = 0; m_st_ok = 0; m_valid = 0;
        end else begin
            tk = (m_cyc % PSC) == PSC - 1;
            m_cyc++;
            rise = pps && !m_pps_q && lock;
            m_pps_q = pps;
            if (!lock) begin
                m_edges = 0; m_ok = 0; m_n = 0; m_st_ok = 0; m_valid = 0;
                m_since += tk;
            end else if (rise) begin
                if (m_edges > 0) begin
                    m_step = (m_since / 10 == 0) ? 1 : m_since / 10;
                    m_ok = 1;
                end
                m_edges++;
                m_since = tk;
                m_n = 0;
                m_valid = m_st_ok;
                if (m_st_ok) m_disp_sec = m_st_sec;
                m_st_ok = 0;
            end else begin
                m_since += tk;
                if (m_ok && tk) m_n++;
            end
            if (lock && ld) begin
                m_st_sec = (bcd2int(s_hh) * 3600 + bcd2int(s_mm) * 60 + bcd2int(s_ss) + 1) % 86400;
                m_st_ok = 1;
            end
        end
    end

    function automatic int exp_tenths();
        int t;
        if (!m_ok) return 0;
        t = m_n / m_step;
        return (t > 9) ? 9 : t;
    endfunction

    // cycle compare against the reference, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (int'(tenths) != exp_tenths()) begin
                errors++;
                $display("FAIL R3 R4 R5 R6 tenths: actual %0d expected %0d at %0t", tenths, exp_tenths(), $time);
            end
            checks++;
            if (valid !== m_valid) begin
                errors++;
                $display("FAIL R8 R9 valid: actual %0b expected %0b at %0t", valid, m_valid, $time);
            end
            checks++;
            if ({hh, mm, ss} !== sec2bcd(m_disp_sec)) begin
                errors++;
                $display("FAIL R7 R8 R11 time: actual %h expected %h at %0t", {hh, mm, ss}, sec2bcd(m_disp_sec), $time);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        s_hh = h; s_mm = m; s_ss = s; ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // raise pps; returns at the negedge right after the rising edge took effect
    task automatic pps_edge();
        pps = 1'b1;
        @(negedge clk);
    endtask

    task automatic pps_low();
        pps = 1'b0;
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk({hh, mm, ss} == 24'h0 && tenths == 0, "R10 time zero", {hh, mm, ss, tenths}, 0);
        chk(!valid, "R10 valid low", valid, 0);

        lock = 1'b1;
        idle(10);
        load(8'h12, 8'h34, 8'h56);
        idle(5);
        // R11 staged time not yet visible
        chk(!valid && {hh, mm, ss} == 24'h0, "R11 no early commit", {valid, hh, mm, ss}, 0);
        pps_edge();
        chk({hh, mm, ss} == 24'h123457 && valid, "R7 R8 commit plus one", {hh, mm, ss}, 24'h123457);
        chk(tenths == 0, "R5 tenths restart", tenths, 0);
        pps_low();
        idle(149);
        chk(tenths == 0, "R6 no pacing after first edge", tenths, 0);
        load(8'h23, 8'h59, 8'h59);
        idle(49);
        pps_edge();
        chk({hh, mm, ss} == 24'h000000 && valid, "R7 midnight wrap", {hh, mm, ss}, 0);
        pps_low();
        idle(149);
        chk(tenths == 7, "R2 R3 tenths at 150 clocks", tenths, 7);
        load(8'h09, 8'h59, 8'h59);
        idle(49);
        pps_edge();
        chk({hh, mm, ss} == 24'h100000, "R7 ten-hour carry", {hh, mm, ss}, 24'h100000);
        pps_low();
        // late pulse: 300 clocks
        idle(249);
        chk(tenths == 9, "R4 hold at nine", tenths, 9);
        load(8'h10, 8'h00, 8'h00);
        idle(49);
        pps_edge();
        chk(tenths == 0, "R5 restart after late edge", tenths, 0);
        chk(ss == 8'h01, "R8 commit after late edge", ss, 1);
        pps_low();
        idle(159);
        chk(tenths == 5, "R2 step from longer interval", tenths, 5);
        idle(40);
        // edge without a staged time
        pps_edge();
        chk(!valid && ss == 8'h01, "R8 no staged time", {valid, ss}, 1);
        pps_low();
        idle(50);
        load(8'h05, 8'h06, 8'h07);
        idle(5);
        lock = 1'b0;
        @(negedge clk);
        chk(!valid && tenths == 0, "R9 lock lost", {valid, tenths}, 0);
        load(8'h01, 8'h02, 8'h03);
        pps_edge();
        pps_low();
        idle(20);
        chk(ss == 8'h01 && !valid, "R9 edge and load ignored", {valid, ss}, 1);
        lock = 1'b1;
        idle(10);
        pps_edge();
        chk(!valid, "R9 staged time discarded", valid, 0);
        pps_low();
        load(8'h07, 8'h08, 8'h09);
        idle(150);
        chk(tenths == 0, "R6 relock waits for second edge", tenths, 0);
        pps_edge();
        chk(valid && {hh, mm, ss} == 24'h070810, "R8 commit after relock", {hh, mm, ss}, 24'h070810);
        pps_low();
        idle(100);
        chk(tenths != 0, "R1 R3 pacing resumes", tenths, 1);
        idle(5);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (TIMEOUT) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule